// File: doc/BRIEF.md
# Three-Level Wavelet Slot Scheduler

This block sequences the filter work of a three-level separable 2-D wavelet decomposition of an N x N image. After a start pulse it walks a grid of slots in raster order, one slot per clock, and reports the slot's column and row. Each slot has a horizontal half and a vertical half. In every slot the block raises at most one horizontal strobe and at most one vertical strobe, and tags each with the resolution level (1, 2 or 3) it belongs to. A shared horizontal filter and a shared pair of vertical filters in the datapath follow these strobes.

Levels 2 and 3 use fixed arithmetic column and row patterns that fall into the slots level 1 leaves idle. Work whose column lies past the end of a row moves to the start of the next row. The whole image, all three levels included, is therefore covered in N*N + 6 slots. A one-cycle done pulse marks the end of the walk.

Top module: `dwt_sched`

## Requirements
- R1: While reset is high and after it is released, the block is idle: both strobes low, both level tags 0, done low, column and row 0.
- R2: A start pulse seen while idle makes the next cycle slot 0 (column 0, row 0). Each following cycle advances by one slot. Slot t is shown as column t mod N and row t div N, for t from 0 to N*N+5.
- R3: Level-1 horizontal work (tag 1) falls on columns 2k+1, k = 0..N/2-1, on every row 0..N-1. That gives N*N/2 per image.
- R4: Level-2 horizontal work (tag 2) falls on columns 4k+6, k = 0..N/4-1, on odd rows. That gives N*N/8 per image.
- R5: Level-3 horizontal work (tag 3) falls on columns 8k+12, k = 0..N/8-1, on rows with row mod 4 = 3. That gives N*N/32 per image.
- R6: Level-1 vertical work (tag 1) falls on columns 2k+2, k = 0..N/2-1, on odd rows. That gives N*N/4 per image.
- R7: Level-2 vertical work (tag 2) falls on columns 4k+7, k = 0..N/4-1, on rows with row mod 4 = 3. That gives N*N/16 per image.
- R8: Level-3 vertical work (tag 3) falls on columns 8k+13, k = 0..N/8-1, on rows with row mod 8 = 7. That gives N*N/64 per image.
- R9: A column c >= N on row y is issued in slot y*N + c, which is column c-N of row y+1. No two levels ever share the same half of a slot. A strobe is high exactly when its tag is non-zero.
- R10: Done is high for exactly one cycle, in the cycle after slot N*N+5. That slot carries the final level-3 vertical strobe.
- R11: A start pulse during a walk is ignored, and the walk continues from where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk when idle |
| h_stb | output | 1 | Horizontal filter strobe |
| h_lvl | output | 2 | Level of horizontal work (0 none, 1..3) |
| v_stb | output | 1 | Vertical filter strobe |
| v_lvl | output | 2 | Level of vertical work (0 none, 1..3) |
| col | output | log2(N) | Current slot column |
| row | output | log2(N)+1 | Current slot row (reaches N in the overflow slots) |
| done | output | 1 | One-cycle pulse after the last slot |

## Verification
Each walk is compared slot by slot against a model that lists every scheduled job in linear slot time. This separates a wrong column pattern, a wrong row pattern and a missing wrap into the next row. Walks start after random idle gaps and get random stray start pulses. The stray pulses show whether a running walk restarts. A reset forced in mid-walk checks the return to idle. Per-level strobe totals, compared with closed-form counts, catch patterns that hit the right positions but the wrong number of rows.

// File: rtl/dwt_sched.sv
module dwt_sched #(
  parameter int N = 16,
  localparam int CW = $clog2(N),
  localparam int RW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          h_stb,
  output logic [1:0]    h_lvl,
  output logic          v_stb,
  output logic [1:0]    v_lvl,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          done
);

  logic          run;
  logic [CW-1:0] x;
  logic [RW-1:0] y;
  logic          done_q;
  logic          last;
  logic [2:0]    hh, vv;

  function automatic logic [2:0] h_at(input int c, input int r);
    h_at[0] = r >= 0 && r < N && c < N && c % 2 == 1;
    h_at[1] = r >= 0 && r < N && r % 2 == 1 && c >= 6 && c % 4 == 2 && c <= N + 2;
    h_at[2] = r >= 0 && r < N && r % 4 == 3 && c >= 12 && c % 8 == 4 && c <= N + 4;
  endfunction

  function automatic logic [2:0] v_at(input int c, input int r);
    v_at[0] = r >= 0 && r < N && r % 2 == 1 && c >= 2 && c % 2 == 0 && c <= N;
    v_at[1] = r >= 0 && r < N && r % 4 == 3 && c >= 7 && c % 4 == 3 && c <= N + 3;
    v_at[2] = r >= 0 && r < N && r % 8 == 7 && c >= 13 && c % 8 == 5 && c <= N + 5;
  endfunction

  function automatic logic [1:0] enc(input logic [2:0] h);
    enc = h[2] ? 2'd3 : h[1] ? 2'd2 : h[0] ? 2'd1 : 2'd0;
  endfunction

  assign last = run && y == RW'(N) && x == CW'(5);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      x      <= '0;
      y      <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          run <= 1'b1;
          x   <= '0;
          y   <= '0;
        end
      end else if (last) begin
        run    <= 1'b0;
        done_q <= 1'b1;
        x      <= '0;
        y      <= '0;
      end else begin
        x <= x + CW'(1);
        if (x == CW'(N - 1)) y <= y + RW'(1);
      end
    end
  end

  // in-row work plus work wrapped from the previous row
  always_comb begin
    hh = h_at(int'(x), int'(y));
    vv = v_at(int'(x), int'(y));
    if (y != '0) begin
      hh = hh | h_at(int'(x) + N, int'(y) - 1);
      vv = vv | v_at(int'(x) + N, int'(y) - 1);
    end
    if (!run) begin
      hh = '0;
      vv = '0;
    end
  end

  assign h_lvl = enc(hh);
  assign v_lvl = enc(vv);
  assign h_stb = |hh;
  assign v_stb = |vv;
  assign col   = x;
  assign row   = y;
  assign done  = done_q;

  AST_H_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst) $onehot0(hh)); // R9
  AST_V_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst) $onehot0(vv)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_AFTER_V3: assert property (@(posedge clk) disable iff (rst) done |-> $past(v_lvl) == 2'd3); // R10
  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (rst) row <= RW'(N)); // R2
  AST_KEEP_WALKING: assert property (@(posedge clk) disable iff (rst)
    (run && !last) |=> col == CW'($past(col) + CW'(1))); // R11

endmodule

// File: tb/tb_dwt_sched.sv
`timescale 1ns/1ps
module tb_dwt_sched;
  localparam int N = 16;
  localparam int CW = $clog2(N);
  localparam int RW = CW + 1;
  localparam int SLOTS = N * N + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic h_stb, v_stb, done;
  logic [1:0] h_lvl, v_lvl;
  logic [CW-1:0] col;
  logic [RW-1:0] row;

  int total = 0;
  int bad = 0;
  int hc[4];
  int vc[4];

  always #4 clk = ~clk;

  dwt_sched #(.N(N)) dut (
    .clk(clk), .rst(rst), .start(start),
    .h_stb(h_stb), .h_lvl(h_lvl), .v_stb(v_stb), .v_lvl(v_lvl),
    .col(col), .row(row), .done(done)
  );

  function automatic int exp_h(input int t);
    for (int y = 0; y < N; y++) begin
      for (int k = 0; k < N / 2; k++) if (y * N + 2 * k + 1 == t) return 1;
      if (y % 2 == 1) for (int k = 0; k < N / 4; k++) if (y * N + 4 * k + 6 == t) return 2;
      if (y % 4 == 3) for (int k = 0; k < N / 8; k++) if (y * N + 8 * k + 12 == t) return 3;
    end
    return 0;
  endfunction

  function automatic int exp_v(input int t);
    for (int y = 0; y < N; y++) begin
      if (y % 2 == 1) for (int k = 0; k < N / 2; k++) if (y * N + 2 * k + 2 == t) return 1;
      if (y % 4 == 3) for (int k = 0; k < N / 4; k++) if (y * N + 4 * k + 7 == t) return 2;
      if (y % 8 == 7) for (int k = 0; k < N / 8; k++) if (y * N + 8 * k + 13 == t) return 3;
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(h_stb == 0 && v_stb == 0, req, {h_stb, v_stb}, 0);
    chk(h_lvl == 0 && v_lvl == 0, req, {h_lvl, v_lvl}, 0);
    chk(col == 0 && row == 0, req, {row, col}, 0);
  endtask

  task automatic walk(input bit noisy);
    int eh, ev;
    for (int l = 0; l < 4; l++) begin hc[l] = 0; vc[l] = 0; end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t < SLOTS; t++) begin
      eh = exp_h(t);
      ev = exp_v(t);
      chk(int'(col) == t % N, "R2 col", col, t % N);
      chk(int'(row) == t / N, "R2 row", row, t / N);
      chk(int'(h_lvl) == eh, eh == 2 ? "R4 h level" : eh == 3 ? "R5 h level" : "R3 h level", h_lvl, eh);
      chk(int'(v_lvl) == ev, ev == 2 ? "R7 v level" : ev == 3 ? "R8 v level" : "R6 v level", v_lvl, ev);
      chk(h_stb == (h_lvl != 0) && v_stb == (v_lvl != 0), "R9 strobe matches tag", {h_stb, v_stb}, {h_lvl != 0, v_lvl != 0});
      chk(!done, "R10 done early", done, 0);
      hc[h_lvl]++;
      vc[v_lvl]++;
      if (noisy && ($urandom % 8 == 0)) start = 1'b1; // R11 stray start
      @(negedge clk) start = 1'b0;
    end
    chk(done == 1'b1, "R10 done pulse", done, 1);
    chk(h_stb == 0 && v_stb == 0, "R10 quiet after last", {h_stb, v_stb}, 0);
    chk(hc[1] == N * N / 2, "R3 count", hc[1], N * N / 2);
    chk(hc[2] == N * N / 8, "R4 count", hc[2], N * N / 8);
    chk(hc[3] == N * N / 32, "R5 count", hc[3], N * N / 32);
    chk(vc[1] == N * N / 4, "R6 count", vc[1], N * N / 4);
    chk(vc[2] == N * N / 16, "R7 count", vc[2], N * N / 16);
    chk(vc[3] == N * N / 64, "R8 count", vc[3], N * N / 64);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    chk_idle("R1 idle after walk");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk(!done, "R1 done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");
    walk(1'b0);
    for (int i = 0; i < 3; i++) begin
      repeat ($urandom % 7) @(negedge clk);
      walk(1'b1);
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40 + $urandom % 50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1 reset mid-walk");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 stays idle without start");
    chk(!done, "R1 no done after abort", done, 0);
    walk(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule